// File: doc/BRIEF.md
# Selectable Frequency Divider Output

This block drives one output pin with a square wave whose rate is picked by software. Two free-running binary counters do the dividing. One advances on ticks of the fast gear clock and the other on ticks of the slow low-frequency clock. A small multiplexer picks one upper counter bit as the output. Which bit it picks depends on a 2-bit rate code and on a source-select input that chooses the fast or the slow counter.

A 3-bit control write port sets an enable flag and the rate code. While the enable flag is clear, or the slow source is paired with its unused code, the pin rests high. A low-power entry request clears the enable flag in hardware. Writes to the control register never touch the counters. Because the counters keep running, the first period after enabling can be short.

Both counters and the control logic sit in one clock domain. The two sources arrive as single-cycle tick enables. The pin is driven from a register.

Top module: `freq_div_out`

## Requirements
- R1: With the fast source selected (src_slow=0), rate codes 0, 1, 2 and 3 drive the pin from fast-counter bits 11, 10, 9 and 8. With one tick per cycle, each half period is 2048, 1024, 512 or 256 cycles (division by 4096, 2048, 1024, 512).
- R2: With the slow source selected (src_slow=1), rate codes 0, 1 and 2 drive the pin from slow-counter bits 4, 3 and 2. This divides the slow tick rate by 32, 16 and 8.
- R3: With the slow source selected, rate code 3 is unused, and the pin is held high while it is active.
- R4: While the enable flag is 0, the pin is held high.
- R5: Each counter advances by one on every cycle where its tick input is 1, and holds otherwise. This happens whatever the enable flag is. A control write never clears a counter.
- R6: A cycle with stop_req=1 clears the enable flag at that edge, even if a write in the same cycle sets it. The pin is high from the second edge onward.
- R7: A write with wr_en=1 loads wr_data[2] as the enable flag and wr_data[1:0] as the rate code at the next edge. The pin reflects the new setting one edge after that.
- R8: Synchronous active-high reset clears the enable flag, the rate code and both counters, and drives the pin high.
- R9: When enabled on a valid code, the pin copies the selected counter bit, delayed by one register. With regular ticks this gives a 50% duty cycle.
- R10: A change of src_slow changes the tap used at the next edge, with no write needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| fast_tick | input | 1 | Advance the fast counter this cycle |
| slow_tick | input | 1 | Advance the slow counter this cycle |
| src_slow | input | 1 | 1 selects the slow counter taps, 0 the fast |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 3 | Bit 2 enable, bits 1:0 rate code |
| stop_req | input | 1 | Low-power entry: clears the enable flag |
| dvo_o | output | 1 | Registered divider output pin |

## Verification
A counter that skips, stalls or is cleared by a write shows up as a wrong half-period length or a phase offset at the pin. This appears within one half period of the selected tap: at most 2048 cycles on the fast source, and within 48 cycles on the slow source with one tick every third cycle. A wrong enable or rate state shows up two edges after the write or stop request that exposes it, as a pin that toggles when it should rest high, or the reverse. The bench runs a cycle-accurate arithmetic model of both counters alongside the design and compares every cycle. It also measures half-period lengths directly against powers of two.

// File: rtl/freq_div_pkg.sv
package freq_div_pkg;
  localparam int RATE_W = 2;
  localparam int NUM_CODES = 1 << RATE_W;
  localparam int CTRL_W = RATE_W + 1;

  typedef logic [RATE_W-1:0] rate_t;

  typedef struct packed {
    logic  en;
    rate_t rate;
  } ctrl_t;
endpackage

// File: rtl/fdo_ctrl_reg.sv
module fdo_ctrl_reg
  import freq_div_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              stop_req,
  output ctrl_t             ctrl_q
);
  ctrl_t wr_val;
  assign wr_val = ctrl_t'(wr_data);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else begin
      if (wr_en) ctrl_q <= wr_val;
      if (stop_req) ctrl_q.en <= 1'b0;
    end
  end
endmodule

// File: rtl/fdo_counter.sv
module fdo_counter #(
  parameter int W = 12,
  parameter int TAPS = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  output logic [TAPS-1:0] taps
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else if (tick) cnt_q <= cnt_q + 1'b1;
  end

  assign taps = cnt_q[W-1 -: TAPS];
endmodule

// File: rtl/fdo_tap_mux.sv
module fdo_tap_mux
  import freq_div_pkg::*;
#(
  parameter int FAST_CODES = 4,
  parameter int SLOW_CODES = 3
) (
  input  logic [FAST_CODES-1:0] fast_taps,
  input  logic [SLOW_CODES-1:0] slow_taps,
  input  logic                  src_slow,
  input  rate_t                 rate,
  output logic                  tap_bit,
  output logic                  reserved
);
  logic [NUM_CODES-1:0] fast_lut;
  logic [NUM_CODES-1:0] slow_lut;
  logic [NUM_CODES-1:0] slow_ok;

  for (genvar c = 0; c < NUM_CODES; c++) begin : g_code
    assign fast_lut[c] = fast_taps[FAST_CODES-1-c];
    if (c < SLOW_CODES) begin : g_valid
      assign slow_lut[c] = slow_taps[SLOW_CODES-1-c];
      assign slow_ok[c]  = 1'b1;
    end else begin : g_resv
      assign slow_lut[c] = 1'b1;
      assign slow_ok[c]  = 1'b0;
    end
  end

  always_comb begin
    tap_bit  = src_slow ? slow_lut[rate] : fast_lut[rate];
    reserved = src_slow & ~slow_ok[rate];
  end
endmodule

// File: rtl/freq_div_out.sv
module freq_div_out
  import freq_div_pkg::*;
#(
  parameter int FAST_W = 12,
  parameter int SLOW_W = 5,
  parameter int SLOW_CODES = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fast_tick,
  input  logic              slow_tick,
  input  logic              src_slow,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              stop_req,
  output logic              dvo_o
);
  localparam int FAST_CODES = NUM_CODES;

  ctrl_t                 ctrl_q;
  logic                  en_q;
  rate_t                 rate_q;
  logic [FAST_CODES-1:0] fast_taps;
  logic [SLOW_CODES-1:0] slow_taps;
  logic                  tap_bit;
  logic                  reserved;
  logic                  dvo_q;

  fdo_ctrl_reg u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .stop_req (stop_req),
    .ctrl_q   (ctrl_q)
  );

  assign en_q   = ctrl_q.en;
  assign rate_q = ctrl_q.rate;

  fdo_counter #(.W(FAST_W), .TAPS(FAST_CODES)) u_fast (
    .clk  (clk),
    .rst  (rst),
    .tick (fast_tick),
    .taps (fast_taps)
  );

  fdo_counter #(.W(SLOW_W), .TAPS(SLOW_CODES)) u_slow (
    .clk  (clk),
    .rst  (rst),
    .tick (slow_tick),
    .taps (slow_taps)
  );

  fdo_tap_mux #(.FAST_CODES(FAST_CODES), .SLOW_CODES(SLOW_CODES)) u_mux (
    .fast_taps (fast_taps),
    .slow_taps (slow_taps),
    .src_slow  (src_slow),
    .rate      (rate_q),
    .tap_bit   (tap_bit),
    .reserved  (reserved)
  );

  always_ff @(posedge clk) begin
    if (rst) dvo_q <= 1'b1;
    else if (!en_q || reserved) dvo_q <= 1'b1;
    else dvo_q <= tap_bit;
  end

  assign dvo_o = dvo_q;
endmodule

// File: rtl/freq_div_out_checker.sv
module freq_div_out_checker
  import freq_div_pkg::*;
#(
  parameter int FAST_CODES = 4
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  fast_tick,
  input logic                  src_slow,
  input logic                  stop_req,
  input logic                  dvo_o,
  input logic                  en_q,
  input rate_t                 rate_q,
  input logic [FAST_CODES-1:0] fast_taps
);
  AST_DISABLED_HIGH: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> dvo_o); // R4
  AST_RESERVED_HIGH: assert property (@(posedge clk) disable iff (rst)
    (src_slow && rate_q == 2'b11) |=> dvo_o); // R3
  AST_STOP_FORCES_HIGH: assert property (@(posedge clk) disable iff (rst)
    stop_req |-> ##2 dvo_o); // R6
  AST_FAST_HOLD: assert property (@(posedge clk) disable iff (rst)
    !fast_tick |=> $stable(fast_taps)); // R5
  AST_FAST_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    (en_q && !src_slow) |=> dvo_o == $past(fast_taps[FAST_CODES-1-int'(rate_q)])); // R9
endmodule

bind freq_div_out freq_div_out_checker #(.FAST_CODES(FAST_CODES)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .fast_tick (fast_tick),
  .src_slow  (src_slow),
  .stop_req  (stop_req),
  .dvo_o     (dvo_o),
  .en_q      (en_q),
  .rate_q    (rate_q),
  .fast_taps (fast_taps)
);

// File: tb/freq_div_out_tb_top.sv
module freq_div_out_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int FW = 12;
  localparam int SW = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fast_tick = 1'b1;
  logic slow_tick = 1'b0;
  logic src_slow = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_data = '0;
  logic stop_req = 1'b0;
  logic dvo_o;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;
  bit fast_alt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  freq_div_out dut_i (
    .clk(clk), .rst(rst), .fast_tick(fast_tick), .slow_tick(slow_tick),
    .src_slow(src_slow), .wr_en(wr_en), .wr_data(wr_data),
    .stop_req(stop_req), .dvo_o(dvo_o)
  );

  // tick generators: slow tick every third cycle, fast tick every cycle or alternating
  int sdiv = 0;
  always @(negedge clk) begin
    sdiv = (sdiv == 2) ? 0 : sdiv + 1;
    slow_tick = (sdiv == 2);
    fast_tick = fast_alt ? ~fast_tick : 1'b1;
  end

  // arithmetic model of the requirements
  logic [FW-1:0] m_fc;
  logic [SW-1:0] m_sc;
  logic m_en, m_exp;
  logic [1:0] m_rt;
  always @(posedge clk) begin
    if (rst) begin
      m_fc <= '0; m_sc <= '0; m_en <= 0; m_rt <= 0; m_exp <= 1;
    end else begin
      if (fast_tick) m_fc <= m_fc + 1'b1;
      if (slow_tick) m_sc <= m_sc + 1'b1;
      if (wr_en) begin m_en <= wr_data[2]; m_rt <= wr_data[1:0]; end
      if (stop_req) m_en <= 0;
      if (!m_en) m_exp <= 1;
      else if (src_slow) m_exp <= (m_rt == 2'd3) ? 1'b1 : m_sc[SW-1-m_rt];
      else m_exp <= m_fc[FW-1-m_rt];
    end
  end

  int mm = 0;
  logic mm_act, mm_exp;
  always @(negedge clk) begin
    if (!rst && dvo_o !== m_exp) begin
      if (mm == 0) begin mm_act = dvo_o; mm_exp = m_exp; end
      mm++;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model_check(input string req, input string what);
    check(mm == 0, req, {what, " (model mismatches)"}, mm, 0);
    mm = 0;
  endtask

  task automatic write_ctrl(input logic en, input logic [1:0] rate);
    @(negedge clk); wr_en = 1; wr_data = {en, rate};
    @(negedge clk); wr_en = 0;
  endtask

  task automatic measure(input int exp_half, input string req, input string what);
    int hi = 0, lo = 0;
    @(negedge clk);
    while (dvo_o !== 1'b0) @(negedge clk);
    while (dvo_o !== 1'b1) @(negedge clk);
    while (dvo_o === 1'b1) begin hi++; @(negedge clk); end
    while (dvo_o === 1'b0) begin lo++; @(negedge clk); end
    check(hi == exp_half, req, {what, " high run"}, hi, exp_half);
    check(lo == exp_half, req, {what, " low run"}, lo, exp_half);
  endtask

  task automatic hold_high(input int n, input string req, input string what);
    int bad = 0;
    for (int i = 0; i < n; i++) begin @(negedge clk); if (dvo_o !== 1'b1) bad++; end
    check(bad == 0, req, {what, " low cycles"}, bad, 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "WDOG", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(dvo_o === 1'b1, "R8", "pin during reset", dvo_o, 1);
    rst = 0;
    @(negedge clk);
    check(dvo_o === 1'b1, "R8", "pin after reset", dvo_o, 1);
    // R4: disabled rests high though counters run
    hold_high(300, "R4", "disabled");
    model_check("R8", "counters start at zero");
    // R1 / R9: fast sweep of every code
    for (int c = 3; c >= 0; c--) begin
      write_ctrl(1, c[1:0]);
      measure(1 << (FW - 1 - c), "R1", $sformatf("fast code %0d", c));
    end
    model_check("R7", "fast writes and counter continuity R5");
    // R5: irregular fast ticks double the half period
    fast_alt = 1;
    write_ctrl(1, 2'd3);
    measure(2 * 256, "R5", "fast code 3 alternate ticks");
    fast_alt = 0;
    model_check("R5", "alternating ticks");
    // R2 / R10: switch source without writing
    @(negedge clk); src_slow = 1;
    for (int c = 0; c < 3; c++) begin
      write_ctrl(1, c[1:0]);
      measure(3 * (1 << (SW - 1 - c)), "R2", $sformatf("slow code %0d", c));
    end
    model_check("R10", "source switch");
    // R3: reserved slow code
    write_ctrl(1, 2'd3);
    @(negedge clk);
    hold_high(400, "R3", "slow reserved code");
    // back to fast mid-stream (R10)
    write_ctrl(1, 2'd3);
    @(negedge clk); src_slow = 0;
    measure(256, "R10", "fast after switch back");
    model_check("R9", "follow tap");
    // R6: stop request
    @(negedge clk); stop_req = 1;
    @(negedge clk); stop_req = 0;
    @(negedge clk);
    check(dvo_o === 1'b1, "R6", "pin two edges after stop", dvo_o, 1);
    hold_high(600, "R6", "after stop");
    // R6: stop beats same-cycle enable write
    @(negedge clk); stop_req = 1; wr_en = 1; wr_data = 3'b111;
    @(negedge clk); stop_req = 0; wr_en = 0;
    hold_high(600, "R6", "stop with write");
    // rate from that write still applied: re-enable with code 3
    write_ctrl(1, 2'd3);
    measure(256, "R7", "re-enable after stop");
    // R4: disable via write
    write_ctrl(0, 2'd3);
    @(negedge clk);
    hold_high(600, "R4", "disabled by write");
    model_check("R6", "stop and disable sequence");
    // R8: reset mid-run
    write_ctrl(1, 2'd3);
    @(negedge clk); rst = 1;
    @(negedge clk);
    check(dvo_o === 1'b1, "R8", "pin at reset mid-run", dvo_o, 1);
    rst = 0;
    write_ctrl(1, 2'd3);
    measure(256, "R8", "restart from zero");
    model_check("R8", "restart");
    finish_run();
  end
endmodule